// File: doc/BRIEF.md
# PCI configuration address generator

This block converts a configuration-space request (bus, device, function, register offset) into the pair of values that a host-to-PCI bridge needs for one configuration access: a 32-bit local-bus address and a 16-bit value for the window-map register. A request on bus zero becomes a type 0 cycle. Here the device is selected by a one-hot bit, which lands either in the address or, when it would fall in the top byte, in the map value. A request on any other bus becomes a type 1 cycle. Here bus, device, function and offset are packed as fields into the address.

Each access is presented in two steps. A one-cycle map strobe carries the map value together with the address. It is followed at once by a one-cycle data strobe with the same address. The block then waits for an acknowledge. A wide (32-bit) request is split by an internal sequencer into two 16-bit accesses, the low half first and the high half at the offset plus two. A type 0 request whose device number has no place for its select bit is refused with an error pulse.

Top module: `cfg_addr_gen`

## Requirements
- R1: A request with bus number 0 produces map code 0x000A in map bits 3:0 (type 0). Any other bus number produces map value 0x000B exactly (type 1).
- R2: For type 0 with device d in 0..12, the address is base OR (function << 8) OR offset OR (1 << (d+11)), and the map value is 0x000A.
- R3: For type 0 with device d in 13..20, the address is base OR (function << 8) OR offset with no select bit. The map value is 0x000A OR (1 << (d+11-16)), which sets one bit in map bits 15:8.
- R4: For type 1, the address is base OR (bus << 16) OR (device << 11) OR (function << 8) OR offset, with the bus in bits 23:16, the device in bits 15:11, the function in bits 10:8 and the offset in bits 7:0.
- R5: A type 0 request with device greater than 20 gives a one-cycle err pulse in the cycle after acceptance. It produces no map strobe, no data strobe and no busy.
- R6: An accepted request gives map_stb high for exactly one cycle, starting the cycle after acceptance. data_stb follows in the next cycle for one cycle, with out_addr and out_map unchanged.
- R7: A wide request issues two accesses. The first uses offset off with out_wdata = wdata[15:0]. The second uses offset (off+2) mod 256 with out_wdata = wdata[31:16], and its map strobe comes in the cycle after the first acknowledge.
- R8: busy is high from the cycle after acceptance until the cycle after the final acknowledge. A request raised while busy is ignored.
- R9: During and right after reset, busy, map_stb, data_stb and err are low.
- R10: A narrow request issues exactly one access with out_wdata = wdata[15:0]. out_we follows the request's write flag. An acknowledge is taken in the data strobe cycle or in any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when not busy |
| req_we | input | 1 | Request is a write |
| req_wide | input | 1 | Split into two 16-bit accesses |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_off | input | 8 | Register offset |
| req_wdata | input | 32 | Write data |
| cfg_base | input | 32 | Configuration window base address |
| acc_ack | input | 1 | Data access acknowledge |
| map_stb | output | 1 | Map register write strobe |
| data_stb | output | 1 | Data access strobe |
| out_addr | output | 32 | Local-bus address |
| out_map | output | 16 | Window-map value |
| out_wdata | output | 16 | Half-word write data |
| out_we | output | 1 | Access is a write |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Device number out of range (pulse) |

## Verification
The bench builds the block with its default widths: an 8-bit bus, a 5-bit device and a 3-bit function on a 32-bit address. At these sizes every device number can be swept for every bus value from 0 to 255. This reaches each placement of the type 0 select bit, the switch into the map value at device 13, the refusals from device 21 upward, and the full type 1 field packing. Wide requests are run with an offset that wraps past 255, with a delayed acknowledge, and with a second request raised in the middle of a sequence.

// File: rtl/cfg_addr_pkg.sv
// Package: shared constants and types for the configuration address generator.
// Assumes a 32-bit local-bus address and a 16-bit window-map register.
package cfg_addr_pkg;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned MAP_W  = 16;
    localparam int unsigned BUS_W  = 8;
    localparam int unsigned DEV_W  = 5;
    localparam int unsigned FN_W   = 3;
    localparam int unsigned OFF_W  = 8;
    localparam int unsigned DATA_W = 32;

    // Map codes: config cycle, low address bits forced zero / taken from config register
    localparam logic [15:0] MAP_TYPE0 = 16'h000A;
    localparam logic [15:0] MAP_TYPE1 = 16'h000B;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAP  = 2'd1,
        ST_DATA = 2'd2,
        ST_WAIT = 2'd3
    } seq_state_t;
endpackage

// File: rtl/cfg_addr_encode.sv
// Module: cfg_addr_encode
// Combinational encoder. It builds the address and map value for one configuration
// access from captured request fields. It assumes the caller has already refused
// type 0 devices whose select bit would fall above the address MSB.
module cfg_addr_encode
    import cfg_addr_pkg::*;
#(
    parameter int unsigned AW       = ADDR_W,
    parameter int unsigned MW       = MAP_W,
    parameter int unsigned BW       = BUS_W,
    parameter int unsigned DW       = DEV_W,
    parameter int unsigned FW       = FN_W,
    parameter int unsigned OW       = OFF_W,
    parameter int unsigned MAP_FROM = 24,
    parameter int unsigned MAP_SHR  = 16
) (
    input  logic [AW-1:0] base,
    input  logic [BW-1:0] bus,
    input  logic [DW-1:0] dev,
    input  logic [FW-1:0] fn,
    input  logic [OW-1:0] off,
    output logic [AW-1:0] addr,
    output logic [MW-1:0] map
);
    localparam int unsigned FN_LSB  = OW;
    localparam int unsigned DEV_LSB = OW + FW;
    localparam int unsigned BUS_LSB = DEV_LSB + DW;
    localparam int unsigned SEL_LSB = DEV_LSB;

    logic [AW-1:0] sel_vec;
    logic [AW-1:0] sel_lo;
    logic [AW-1:0] sel_hi_full;
    logic [MW-1:0] map_sel;
    logic [AW-1:0] common;

    // One-hot device select: bit i is set when dev == i - SEL_LSB
    for (genvar i = 0; i < int'(AW); i++) begin : g_sel
        if (i >= int'(SEL_LSB)) begin : g_on
            assign sel_vec[i] = (dev == DW'(i - int'(SEL_LSB)));
        end else begin : g_off
            assign sel_vec[i] = 1'b0;
        end
    end

    assign sel_lo      = {{(AW-MAP_FROM){1'b0}}, sel_vec[MAP_FROM-1:0]};
    assign sel_hi_full = {sel_vec[AW-1:MAP_FROM], {MAP_FROM{1'b0}}};
    assign map_sel     = MW'(sel_hi_full >> MAP_SHR);
    assign common      = base | (AW'(fn) << FN_LSB) | AW'(off);

    // Select cycle type from bus number and assemble address and map value
    always_comb begin
        if (bus == '0) begin
            addr = common | sel_lo;
            map  = MW'(MAP_TYPE0) | map_sel;
        end else begin
            addr = common | (AW'(bus) << BUS_LSB) | (AW'(dev) << DEV_LSB);
            map  = MW'(MAP_TYPE1);
        end
    end
endmodule

// File: rtl/cfg_split_seq.sv
// Module: cfg_split_seq
// Access sequencer. Per access it gives a map strobe, then a data strobe, then waits
// for an acknowledge. A wide request repeats this once for the upper half. It assumes
// `bad` is valid in the same cycle as `start`.
module cfg_split_seq
    import cfg_addr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic wide,
    input  logic bad,
    input  logic ack,
    output logic accept,
    output logic map_stb,
    output logic data_stb,
    output logic busy,
    output logic upper,
    output logic err
);
    seq_state_t state;
    logic       wide_q;

    assign busy     = (state != ST_IDLE);
    assign accept   = start && !busy && !bad;
    assign map_stb  = (state == ST_MAP);
    assign data_stb = (state == ST_DATA);

    // State advance, half tracking and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            wide_q <= 1'b0;
            upper  <= 1'b0;
            err    <= 1'b0;
        end else begin
            err <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && bad) begin
                        err <= 1'b1;
                    end else if (start) begin
                        state  <= ST_MAP;
                        wide_q <= wide;
                        upper  <= 1'b0;
                    end
                end
                ST_MAP: state <= ST_DATA;
                ST_DATA, ST_WAIT: begin
                    if (ack) begin
                        if (wide_q && !upper) begin
                            upper <= 1'b1;
                            state <= ST_MAP;
                        end else begin
                            upper <= 1'b0;
                            state <= ST_IDLE;
                        end
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_addr_gen.sv
// Module: cfg_addr_gen (top)
// Configuration address generator. It captures a request, refuses type 0 devices
// with no room for their select bit, and drives address, map value and half-word
// data through the sequencer's strobes. It assumes the request fields are only
// sampled in the cycle where req_valid is seen while idle.
module cfg_addr_gen
    import cfg_addr_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned MW = MAP_W,
    parameter int unsigned BW = BUS_W,
    parameter int unsigned DW = DEV_W,
    parameter int unsigned FW = FN_W,
    parameter int unsigned OW = OFF_W,
    parameter int unsigned XW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic          req_wide,
    input  logic [BW-1:0] req_bus,
    input  logic [DW-1:0] req_dev,
    input  logic [FW-1:0] req_fn,
    input  logic [OW-1:0] req_off,
    input  logic [XW-1:0] req_wdata,
    input  logic [AW-1:0] cfg_base,
    input  logic          acc_ack,
    output logic          map_stb,
    output logic          data_stb,
    output logic [AW-1:0] out_addr,
    output logic [MW-1:0] out_map,
    output logic [XW/2-1:0] out_wdata,
    output logic          out_we,
    output logic          busy,
    output logic          err
);
    localparam int unsigned HW        = XW / 2;
    localparam int unsigned HALF_STEP = HW / 8;
    localparam int unsigned SEL_LSB   = OW + FW;
    localparam int unsigned DEV_MAX   = AW - 1 - SEL_LSB;

    logic          accept;
    logic          upper;
    logic          in_bad;
    logic [AW-1:0] q_base;
    logic [BW-1:0] q_bus;
    logic [DW-1:0] q_dev;
    logic [FW-1:0] q_fn;
    logic [OW-1:0] q_off;
    logic [XW-1:0] q_wdata;
    logic          q_we;
    logic [OW-1:0] cur_off;

    // Refuse type 0 devices whose select bit lies above the address MSB
    assign in_bad = (req_bus == '0) && (32'(req_dev) > DEV_MAX);

    // Capture request fields on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_base  <= '0;
            q_bus   <= '0;
            q_dev   <= '0;
            q_fn    <= '0;
            q_off   <= '0;
            q_wdata <= '0;
            q_we    <= 1'b0;
        end else if (accept) begin
            q_base  <= cfg_base;
            q_bus   <= req_bus;
            q_dev   <= req_dev;
            q_fn    <= req_fn;
            q_off   <= req_off;
            q_wdata <= req_wdata;
            q_we    <= req_we;
        end
    end

    // Offset and data half for the access in progress
    always_comb begin
        cur_off   = upper ? (q_off + OW'(HALF_STEP)) : q_off;
        out_wdata = upper ? q_wdata[XW-1:HW] : q_wdata[HW-1:0];
    end

    assign out_we = q_we;

    cfg_split_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (req_valid),
        .wide     (req_wide),
        .bad      (in_bad),
        .ack      (acc_ack),
        .accept   (accept),
        .map_stb  (map_stb),
        .data_stb (data_stb),
        .busy     (busy),
        .upper    (upper),
        .err      (err)
    );

    cfg_addr_encode #(
        .AW (AW), .MW (MW), .BW (BW), .DW (DW), .FW (FW), .OW (OW)
    ) u_enc (
        .base (q_base),
        .bus  (q_bus),
        .dev  (q_dev),
        .fn   (q_fn),
        .off  (cur_off),
        .addr (out_addr),
        .map  (out_map)
    );
endmodule

// File: rtl/cfg_addr_gen_chk.sv
// Module: cfg_addr_gen_chk
// Protocol checker for cfg_addr_gen, attached through bind.
module cfg_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        map_stb,
    input logic        data_stb,
    input logic        busy,
    input logic        err,
    input logic [31:0] out_addr,
    input logic [15:0] out_map
);
    a_r6_map_then_data: assert property (@(posedge clk) disable iff (!rst_n)
        map_stb |=> data_stb);
    a_r6_held_values: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |-> ($stable(out_addr) && $stable(out_map)));
    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({map_stb, data_stb, err}));
    a_r8_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (map_stb || data_stb) |-> busy);
    a_r5_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !map_stb && !data_stb));
    a_r1_map_code: assert property (@(posedge clk) disable iff (!rst_n)
        map_stb |-> (out_map[3:0] == 4'hA || out_map[3:0] == 4'hB));
    a_r4_type1_map: assert property (@(posedge clk) disable iff (!rst_n)
        (map_stb && out_map[3:0] == 4'hB) |-> (out_map[15:4] == 12'h000));
    a_r3_map_select: assert property (@(posedge clk) disable iff (!rst_n)
        (map_stb && out_map[3:0] == 4'hA) |-> ($onehot0(out_map[15:8]) && out_map[7:4] == 4'h0));
endmodule

bind cfg_addr_gen cfg_addr_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .map_stb  (map_stb),
    .data_stb (data_stb),
    .busy     (busy),
    .err      (err),
    .out_addr (out_addr),
    .out_map  (out_map)
);

// File: tb/sim_cfg_addr_gen.sv
// Bench: sweeps devices, buses and functions; expected values computed arithmetically.
module sim_cfg_addr_gen;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic        req_wide = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [7:0]  req_off = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] cfg_base = 32'h6200_0000;
    logic        acc_ack = 1'b0;
    logic        map_stb, data_stb, out_we, busy, err;
    logic [31:0] out_addr;
    logic [15:0] out_map;
    logic [15:0] out_wdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    cfg_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_wide(req_wide), .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn),
        .req_off(req_off), .req_wdata(req_wdata), .cfg_base(cfg_base),
        .acc_ack(acc_ack), .map_stb(map_stb), .data_stb(data_stb),
        .out_addr(out_addr), .out_map(out_map), .out_wdata(out_wdata),
        .out_we(out_we), .busy(busy), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] e_addr(logic [31:0] base, logic [7:0] bus, int dev,
                                           logic [2:0] fn, logic [7:0] off);
        logic [31:0] a;
        a = base | (32'(fn) << 8) | 32'(off);
        if (bus == 8'd0) begin
            if (dev + 11 <= 23) a = a | (32'd1 << (dev + 11));
        end else begin
            a = a | (32'(bus) << 16) | (32'(dev) << 11);
        end
        return a;
    endfunction

    function automatic logic [15:0] e_map(logic [7:0] bus, int dev);
        if (bus != 8'd0) return 16'h000B;
        if (dev + 11 >= 24) return 16'h000A | (16'd1 << (dev + 11 - 16));
        return 16'h000A;
    endfunction

    // One full request; intrude raises a stray request during the first half
    task automatic run_req(input logic [7:0] bus, input int dev, input logic [2:0] fn,
                           input logic [7:0] off, input logic [31:0] wd, input bit wide,
                           input bit we, input int wait_n, input bit intrude);
        string tag;
        @(negedge clk);
        req_valid = 1'b1; req_bus = bus; req_dev = 5'(dev); req_fn = fn; req_off = off;
        req_wdata = wd; req_wide = wide; req_we = we;
        @(negedge clk);
        req_valid = 1'b0;
        for (int h = 0; h < (wide ? 2 : 1); h++) begin
            logic [7:0]  o;
            logic [15:0] hw;
            o  = off + 8'(2 * h);
            hw = (h == 0) ? wd[15:0] : wd[31:16];
            tag = (bus == 0) ? ((dev <= 12) ? "R2" : "R3") : "R4";
            chk(map_stb === 1'b1 && data_stb === 1'b0, "R6 map strobe", {30'd0, map_stb, data_stb}, 32'h2);
            chk(out_addr === e_addr(cfg_base, bus, dev, fn, o), tag, out_addr, e_addr(cfg_base, bus, dev, fn, o));
            chk(out_map === e_map(bus, dev), "R1 map value", 32'(out_map), 32'(e_map(bus, dev)));
            chk(out_wdata === hw, wide ? "R7 half data" : "R10 narrow data", 32'(out_wdata), 32'(hw));
            chk(out_we === we && busy === 1'b1, "R10 we/R8 busy", {30'd0, out_we, busy}, {30'd0, we, 1'b1});
            @(negedge clk);
            chk(data_stb === 1'b1 && map_stb === 1'b0, "R6 data strobe", {30'd0, map_stb, data_stb}, 32'h1);
            chk(out_addr === e_addr(cfg_base, bus, dev, fn, o), "R6 addr held", out_addr, e_addr(cfg_base, bus, dev, fn, o));
            if (intrude && h == 0) begin
                req_valid = 1'b1; req_bus = 8'h33; req_dev = 5'd3; req_off = 8'h40;
            end
            for (int w = 0; w < wait_n; w++) begin
                @(negedge clk);
                req_valid = 1'b0;
                chk(busy === 1'b1 && !map_stb && !data_stb, "R8 wait ack", {29'd0, busy, map_stb, data_stb}, 32'h4);
            end
            acc_ack = 1'b1;
            @(negedge clk);
            acc_ack = 1'b0;
            req_valid = 1'b0;
        end
        chk(busy === 1'b0 && map_stb === 1'b0, "R8 idle after ack", {30'd0, busy, map_stb}, 32'h0);
        if (intrude) begin
            @(negedge clk);
            chk(busy === 1'b0 && map_stb === 1'b0, "R8 stray ignored", {30'd0, busy, map_stb}, 32'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !map_stb && !data_stb && !err, "R9 in reset", {28'd0, busy, map_stb, data_stb, err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !map_stb && !data_stb && !err, "R9 after reset", {28'd0, busy, map_stb, data_stb, err}, 32'h0);

        // R2/R3: type 0, every valid device and function, narrow and wide
        for (int d = 0; d <= 20; d++)
            for (int f = 0; f < 8; f++)
                run_req(8'd0, d, 3'(f), 8'(d * 7 + f * 13), 32'hA5C3_0000 + 32'(d * 8 + f),
                        (f % 2) == 1, (f % 3) != 0, 0, 1'b0);

        // R5: refused devices
        for (int d = 21; d < 32; d++) begin
            @(negedge clk);
            req_valid = 1'b1; req_bus = 8'd0; req_dev = 5'(d); req_wide = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
            chk(err === 1'b1 && !busy && !map_stb, "R5 err pulse", {29'd0, err, busy, map_stb}, 32'h4);
            @(negedge clk);
            chk(err === 1'b0 && !map_stb && !data_stb, "R5 err ends", {29'd0, err, map_stb, data_stb}, 32'h0);
        end

        // R4: type 1, every bus and device
        cfg_base = 32'h5100_0000;
        for (int b = 1; b < 256; b++)
            for (int d = 0; d < 32; d++)
                run_req(8'(b), d, 3'(b + d), 8'(b ^ (d * 4)), 32'(b * 977 + d), 1'b0, 1'b0, 0, 1'b0);

        // R7: offset wrap, delayed ack; R8: stray request while busy
        run_req(8'd0, 5, 3'd2, 8'hFE, 32'h1234_5678, 1'b1, 1'b1, 3, 1'b0);
        run_req(8'd7, 9, 3'd5, 8'h10, 32'hDEAD_BEEF, 1'b1, 1'b1, 2, 1'b1);
        run_req(8'd0, 17, 3'd1, 8'h08, 32'hCAFE_F00D, 1'b1, 1'b1, 0, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule